// File: doc/BRIEF.md
# Two-Lane SIMD Floating-Point Status and Control Register

This block holds the 32-bit status and control word of a two-lane SIMD unit that runs integer and single-precision floating-point operations on a high lane and a low lane at once. When an instruction completes, the execution unit raises a valid strobe. It also presents each lane's overflow, guard, sticky, underflow and overflow result flags, together with the lane operands and a divide indication. The block classifies the operands itself to produce each lane's invalid and divide-by-zero flags. It then overwrites the per-lane flags and accumulates the summary and sticky bits. On the following cycle it raises an exception request when an enabled error class was hit.

Software loads the writable fields through a move-to-register write port. The write takes priority over a flag update in the same cycle, and it is the only way to clear a summary or sticky bit. A read port returns the whole word. The rounding-mode field is also driven out directly to the arithmetic datapath.

Bits carry architectural numbers 32 to 63, counted from the most significant end. Architectural bit n sits at `rdata[63-n]`. Result flag buses are ordered `{ov, guard, sticky, underflow, overflow}`, from bit 4 down to bit 0.

Top module: `lane_fp_status_reg`

## Requirements
- R1: After reset every bit of `rdata` is 0, and `round_mode` is 00 (round to nearest).
- R2: Reserved bits 40, 41 and 56 (`rdata[23]`, `rdata[22]`, `rdata[7]`) and the mode bit 47 (`rdata[16]`) always read 0. A write of 1 to them has no effect.
- R3: When `sw_we` is high, all other bits take `sw_wdata` at the next edge. This holds even when `instr_valid` is high in the same cycle, in which case that instruction's flag update is dropped and no exception request results.
- R4: On each `instr_valid` cycle, the per-lane flags are overwritten with that instruction's flags. High lane: ov 33, guard 34, sticky 35, invalid 36, div-by-zero 37, underflow 38, overflow 39. Low lane: bits 49 to 55 in the same order. Without `instr_valid` or `sw_we` the whole word holds its value.
- R5: A lane's invalid flag is set when either operand of that lane has an all-ones exponent (infinity or NaN), or has a zero exponent with a nonzero fraction (denormal). On a divide it is also set when both operands are zero.
- R6: A lane's divide-by-zero flag is set on a divide whose dividend (operand A) is nonzero and whose divisor (operand B) is ±0.
- R7: Summary overflow bit 32 (high lane) and bit 48 (low lane) are set by any instruction that sets that lane's overflow flag (bits 33 and 49). They stay set until software writes them to 0.
- R8: Inexact sticky bit 42 is set by any instruction whose guard or sticky flag is set in either lane, and it stays set until software writes it.
- R9: Divide-by-zero sticky bit 44 is set by any instruction that sets either lane's divide-by-zero flag, and it stays set until software writes it.
- R10: `exc_req` is 1 in the cycle after an instruction exactly when an enabled class was hit in either lane: invalid (enable bit 58), inexact through guard or sticky (57), divide-by-zero (59), underflow (60) or overflow (61). Otherwise it is 0.
- R11: `round_mode` equals bits 62 to 63 (`rdata[1:0]`): 00 nearest, 01 toward zero, 10 toward +infinity, 11 toward −infinity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction completes this cycle |
| is_div | input | 1 | Completing instruction is a divide |
| hi_res | input | 5 | High-lane result flags {ov, guard, sticky, unf, ovf} |
| lo_res | input | 5 | Low-lane result flags {ov, guard, sticky, unf, ovf} |
| hi_opa | input | 32 | High-lane operand A (dividend) |
| hi_opb | input | 32 | High-lane operand B (divisor) |
| lo_opa | input | 32 | Low-lane operand A (dividend) |
| lo_opb | input | 32 | Low-lane operand B (divisor) |
| sw_we | input | 1 | Software write strobe |
| sw_wdata | input | 32 | Software write data |
| rdata | output | 32 | Whole register word |
| round_mode | output | 2 | Rounding-mode control |
| exc_req | output | 1 | Floating-point data-exception request |

## Verification
The hardest case to reach from the ports is a software write and an instruction completion in the same cycle. The write must win for every bit, and the exception request must stay low even though the colliding instruction carries enabled error flags. The bench reaches this case by first setting the enables, and then driving `sw_we` and `instr_valid` on the same falling edge with flags that would otherwise set sticky bits and raise a request. A second hard case is the accumulate-then-hold behaviour of the sticky bits. The bench checks it by issuing a flagged instruction, then a clean instruction, and then idle cycles. Only after that does it clear the sticky bits by a write.

// File: rtl/lane_fp_status_reg.sv
module lane_fp_status_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         instr_valid,
  input  logic         is_div,
  input  logic [4:0]   hi_res,
  input  logic [4:0]   lo_res,
  input  logic [31:0]  hi_opa,
  input  logic [31:0]  hi_opb,
  input  logic [31:0]  lo_opa,
  input  logic [31:0]  lo_opb,
  input  logic         sw_we,
  input  logic [W-1:0] sw_wdata,
  output logic [W-1:0] rdata,
  output logic [1:0]   round_mode,
  output logic         exc_req
);

  localparam logic [W-1:0] WMASK = ~((W'(1) << 23) | (W'(1) << 22) |
                                     (W'(1) << 16) | (W'(1) << 7));

  function automatic logic is_special(input logic [31:0] v);
    return (v[30:23] == 8'hFF) || (v[30:23] == 8'h00 && v[22:0] != '0);
  endfunction

  function automatic logic is_zero(input logic [31:0] v);
    return v[30:0] == '0;
  endfunction

  logic [W-1:0] q, nxt;
  logic hinv, linv, hdbz, ldbz, inexact, exc_hit;

  assign hinv = is_special(hi_opa) | is_special(hi_opb) |
                (is_div & is_zero(hi_opa) & is_zero(hi_opb));
  assign linv = is_special(lo_opa) | is_special(lo_opb) |
                (is_div & is_zero(lo_opa) & is_zero(lo_opb));
  assign hdbz = is_div & ~is_zero(hi_opa) & is_zero(hi_opb);
  assign ldbz = is_div & ~is_zero(lo_opa) & is_zero(lo_opb);
  assign inexact = hi_res[3] | hi_res[2] | lo_res[3] | lo_res[2];

  always_comb begin
    nxt = q;
    nxt[30:24] = {hi_res[4:2], hinv, hdbz, hi_res[1:0]};
    nxt[14:8]  = {lo_res[4:2], linv, ldbz, lo_res[1:0]};
    nxt[31] = q[31] | hi_res[4];
    nxt[15] = q[15] | lo_res[4];
    nxt[21] = q[21] | inexact;
    nxt[19] = q[19] | hdbz | ldbz;
  end

  assign exc_hit = (q[5] & (hinv | linv)) | (q[6] & inexact) |
                   (q[4] & (hdbz | ldbz)) |
                   (q[3] & (hi_res[1] | lo_res[1])) |
                   (q[2] & (hi_res[0] | lo_res[0]));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= '0;
      exc_req <= 1'b0;
    end else begin
      if (sw_we) q <= sw_wdata & WMASK;
      else if (instr_valid) q <= nxt;
      exc_req <= instr_valid & ~sw_we & exc_hit;
    end
  end

  assign rdata = q;
  assign round_mode = q[1:0];

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata[23] | rdata[22] | rdata[16] | rdata[7]) == 1'b0); // R2
  AST_SW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    sw_we |=> (rdata == ($past(sw_wdata) & WMASK)) && !exc_req); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_we && !instr_valid) |=> $stable(rdata)); // R4
  AST_SOV_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_we && (rdata[31] || rdata[15])) |=> (rdata[31] || !$past(rdata[31])) &&
                                            (rdata[15] || !$past(rdata[15]))); // R7
  AST_DBZS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_we && instr_valid && (hdbz || ldbz)) |=> rdata[19]); // R9
  AST_EXC_NEEDS_INSTR: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |=> !exc_req); // R10
  AST_RMODE: assert property (@(posedge clk) disable iff (!rst_n)
    round_mode == {rdata[1], rdata[0]}); // R11

endmodule

// File: tb/lane_fp_status_reg_bench.sv
module lane_fp_status_reg_bench;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic instr_valid = 0, is_div = 0, sw_we = 0;
  logic [4:0] hi_res = 0, lo_res = 0;
  logic [31:0] hi_opa = 0, hi_opb = 0, lo_opa = 0, lo_opb = 0, sw_wdata = 0;
  logic [31:0] rdata;
  logic [1:0] round_mode;
  logic exc_req;
  int checks = 0, errors = 0;
  bit done = 0;

  localparam logic [31:0] ONE = 32'h3F80_0000, TWO = 32'h4000_0000,
    INF = 32'h7F80_0000, NAN = 32'h7FC0_0000, DEN = 32'h0000_0001, ZRO = 32'h0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_fp_status_reg u_lane_fp_status_reg (.*);

  function automatic int p(int n); return 63 - n; endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic swr(logic [31:0] d);
    @(negedge clk); sw_we = 1; sw_wdata = d;
    @(negedge clk); sw_we = 0;
  endtask

  task automatic issue(logic [4:0] hf, logic [4:0] lf, logic dv,
                       logic [31:0] ha, logic [31:0] hb, logic [31:0] la, logic [31:0] lb);
    @(negedge clk);
    instr_valid = 1; hi_res = hf; lo_res = lf; is_div = dv;
    hi_opa = ha; hi_opb = hb; lo_opa = la; lo_opb = lb;
    @(negedge clk);
    instr_valid = 0; hi_res = 0; lo_res = 0; is_div = 0;
    hi_opa = ONE; hi_opb = ONE; lo_opa = ONE; lo_opb = ONE;
  endtask

  task automatic t_reset;
    check("R1 word", rdata, 32'h0);
    check("R1 rmode", {30'b0, round_mode}, 32'h0);
    check("R1 exc", {31'b0, exc_req}, 32'h0);
  endtask

  task automatic t_write;
    swr(32'hFFFF_FFFF);
    check("R2 R3 all-ones write", rdata, 32'hFF3E_FF7F);
    check("R11 rmode 11", {30'b0, round_mode}, 32'd3);
    for (int m = 0; m < 4; m++) begin
      swr(32'(m));
      check("R11 rmode", {30'b0, round_mode}, 32'(m));
    end
    swr(32'h0);
  endtask

  task automatic t_overflow;
    issue(5'b10010, 5'b0, 0, ONE, ONE, ONE, ONE);
    check("R4 ovh", 32'(rdata[p(33)]), 1);
    check("R4 funfh", 32'(rdata[p(38)]), 1);
    check("R7 sovh set", 32'(rdata[p(32)]), 1);
    issue(5'b0, 5'b10001, 0, ONE, ONE, ONE, ONE);
    check("R4 ovh overwritten", 32'(rdata[p(33)]), 0);
    check("R7 sovh held", 32'(rdata[p(32)]), 1);
    check("R7 sov low set", 32'(rdata[p(48)]), 1);
    check("R4 fovf low", 32'(rdata[p(55)]), 1);
    repeat (3) @(negedge clk);
    check("R4 idle hold", rdata, (32'h1 << p(32)) | (32'h1 << p(48)) |
                                 (32'h1 << p(49)) | (32'h1 << p(55)));
    swr(32'h0);
    check("R7 cleared by write", rdata, 32'h0);
  endtask

  task automatic t_classify;
    issue(0, 0, 0, NAN, ONE, ONE, TWO);
    check("R5 nan high", 32'(rdata[p(36)]), 1);
    check("R5 low clean", 32'(rdata[p(52)]), 0);
    issue(0, 0, 0, ONE, INF, DEN, ONE);
    check("R5 inf+denorm", {30'b0, rdata[p(36)], rdata[p(52)]}, 32'd3);
    issue(0, 0, 1, ONE, TWO, ZRO, ZRO);
    check("R5 0/0 low inv", 32'(rdata[p(52)]), 1);
    check("R6 0/0 no dbz", 32'(rdata[p(53)]), 0);
    check("R5 high clean", 32'(rdata[p(36)]), 0);
    issue(0, 0, 1, ONE, ONE, TWO, 32'h8000_0000);
    check("R6 low dbz", 32'(rdata[p(53)]), 1);
    check("R9 dbzs", 32'(rdata[p(44)]), 1);
    issue(0, 0, 0, ZRO, ZRO, ZRO, ZRO);
    check("R6 non-div no dbz", 32'(rdata[p(53)]), 0);
    check("R9 dbzs held", 32'(rdata[p(44)]), 1);
    swr(0);
  endtask

  task automatic t_inexact;
    issue(0, 5'b00100, 0, ONE, ONE, ONE, ONE);
    check("R8 sticky sets finxs", 32'(rdata[p(42)]), 1);
    issue(0, 0, 0, ONE, ONE, ONE, ONE);
    check("R8 finxs held", 32'(rdata[p(42)]), 1);
    check("R4 fx low cleared", 32'(rdata[p(51)]), 0);
    swr(0);
    check("R8 cleared", 32'(rdata[p(42)]), 0);
  endtask

  task automatic t_exc;
    issue(0, 0, 1, ONE, ZRO, ONE, ONE);
    check("R10 dbz disabled", {31'b0, exc_req}, 0);
    swr(32'h1 << p(59));
    issue(0, 0, 1, ONE, ZRO, ONE, ONE);
    check("R10 dbz enabled", {31'b0, exc_req}, 1);
    @(negedge clk);
    check("R10 drops", {31'b0, exc_req}, 0);
    swr(32'h1 << p(61));
    issue(0, 5'b00010, 0, ONE, ONE, ONE, ONE);
    check("R10 unf not enabled", {31'b0, exc_req}, 0);
    issue(0, 5'b00001, 0, ONE, ONE, ONE, ONE);
    check("R10 ovf enabled", {31'b0, exc_req}, 1);
    swr(32'h1 << p(60));
    issue(5'b00010, 0, 0, ONE, ONE, ONE, ONE);
    check("R10 unf enabled", {31'b0, exc_req}, 1);
    swr(32'h1 << p(58));
    issue(0, 0, 0, ONE, ONE, INF, ONE);
    check("R10 inv enabled", {31'b0, exc_req}, 1);
    swr(32'h1 << p(57));
    issue(5'b01000, 0, 0, ONE, ONE, ONE, ONE);
    check("R10 inexact enabled", {31'b0, exc_req}, 1);
    issue(5'b10011, 0, 0, ONE, ONE, ONE, ONE);
    check("R10 other class only", {31'b0, exc_req}, 0);
    swr(0);
  endtask

  task automatic t_prio;
    swr(32'h1 << p(59));
    @(negedge clk);
    sw_we = 1; sw_wdata = (32'h1 << p(59)) | 32'h2;
    instr_valid = 1; is_div = 1; hi_res = 5'b11111; lo_res = 5'b11111;
    hi_opa = ONE; hi_opb = ZRO; lo_opa = ONE; lo_opb = ONE;
    @(negedge clk);
    sw_we = 0; instr_valid = 0; is_div = 0; hi_res = 0; lo_res = 0;
    check("R3 write wins", rdata, (32'h1 << p(59)) | 32'h2);
    check("R3 no exc on collision", {31'b0, exc_req}, 0);
    check("R11 rmode 10", {30'b0, round_mode}, 32'd2);
    swr(0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_write();
    t_overflow();
    t_classify();
    t_inexact();
    t_exc();
    t_prio();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule